// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational binary adder for two 16-bit operands plus a carry input. It returns the 16-bit sum and the carry out of the top bit. The operands are split into 4-bit groups. Every group derives its own internal carries from per-bit generate and propagate terms. Each group also condenses its four bits into a single group generate and a single group propagate.

A second lookahead stage takes those group terms and forms the carry into every group directly, as a sum of products. No carry travels serially from one group to the next, so the logic depth grows with the number of lookahead levels and not with the operand width.

The operand width and the group width are parameters. Making the operands 32 bits wide adds groups to the second stage; nothing else changes. Signed overflow detection and pipeline registers are not part of this block.

Top module: `cla_adder`

## Requirements
- R1: Bit i asserts its generate term exactly when both operand bits i are 1 (g = a AND b), so that bit alone sends a carry into bit i+1 whatever carry it receives.
- R2: Bit i asserts its propagate term when at least one operand bit i is 1 (p = a OR b), so an incoming carry at bit i passes on to bit i+1.
- R3: Inside a 4-bit group, the carry into bit k is the OR over j<k of g_j ANDed with p of every bit between j and k, ORed with the group carry-in ANDed with p of all bits below k. Bit 0 of the group receives the group carry-in itself.
- R4: A group's generate is g3 + p3g2 + p3p2g1 + p3p2p1g0. Its propagate is p3p2p1p0. Generate OR (propagate AND group carry-in) equals the carry that leaves the group's top bit.
- R5: The carry into group j (j = 1, 2, 3) and the final carry are built by applying the R3 equations to the group generate and propagate terms and carry_in, with no group waiting on the carry of the group below it.
- R6: Sum bit i is a_i XOR b_i XOR c_i. Taken together, sum_out equals (a_in + b_in + carry_in) modulo 2^16.
- R7: carry_out equals bit 16 of the 17-bit result a_in + b_in + carry_in.
- R8: When a_in is all ones, b_in is zero and carry_in is 1, the carry passes through every bit: sum_out is 0x0000 and carry_out is 1.
- R9: When a carry arises in the top bit of one group and every bit of the next group propagates, that carry reaches the group after it. The sum bits of the propagating group all become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand, unsigned |
| b_in | input | 16 | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of a_in + b_in + carry_in |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bench applies several kinds of operand pairs and carry-in values, each aimed at a different fault.

- Equal operands make every active bit a generate-only bit. This separates the generate term from the propagate term.
- A one-hot operand added to a run of ones drives a carry through propagate-only bits, either inside one group or across group edges.
- A carry placed at the top of each group checks that the second stage delivers it to exactly the correct later group.
- All ones plus a carry-in, and all ones plus zero, exercise the longest propagate chain with the carry on and with it off.
- A long random run compares sum_out and carry_out against plain integer addition, which catches wrong product terms anywhere in the two lookahead levels.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Shared lookahead helpers for the adder. la_carry computes a carry as a flat
// sum of products. rip_carry computes the same carry by serial recurrence and
// is used only as a reference inside the assertions.
// Assumes: vectors are at most 64 entries wide; unused upper entries are zero.
package cla_pkg;

    localparam int unsigned LA_MAX = 64;

    // Carry into position idx from generate/propagate vectors and carry c0.
    function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                      input logic [LA_MAX-1:0] p,
                                      input logic              c0,
                                      input int unsigned       idx);
        logic res;
        logic term;
        res = 1'b0;
        for (int unsigned k = 0; k < LA_MAX; k++) begin
            if (k < idx) begin
                term = g[k];
                for (int unsigned m = 0; m < LA_MAX; m++) begin
                    if (m > k && m < idx) term = term & p[m];
                end
                res = res | term;
            end
        end
        term = c0;
        for (int unsigned m = 0; m < LA_MAX; m++) begin
            if (m < idx) term = term & p[m];
        end
        return res | term;
    endfunction

    // Reference carry by serial recurrence, used only by assertions.
    function automatic logic rip_carry(input logic [LA_MAX-1:0] g,
                                       input logic [LA_MAX-1:0] p,
                                       input logic              c0,
                                       input int unsigned       idx);
        logic c;
        c = c0;
        for (int unsigned k = 0; k < LA_MAX; k++) begin
            if (k < idx) c = g[k] | (p[k] & c);
        end
        return c;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
// Module cla_bit_gp
// Forms the per-bit generate and propagate terms for all operand bits.
// Assumes: purely combinational, operands already aligned bit for bit.
module cla_bit_gp #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_bits,
    input  logic [WIDTH-1:0] b_bits,
    output logic [WIDTH-1:0] gen_bits,
    output logic [WIDTH-1:0] prop_bits
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Generate and propagate terms of bit i.
        always_comb begin
            gen_bits[i]  = a_bits[i] & b_bits[i];
            prop_bits[i] = a_bits[i] | b_bits[i];
            AST_GEN_IMPLIES_PROP: assert (!(gen_bits[i] && !prop_bits[i])) else $error("generate without propagate at bit %0d", i); // R1
        end
    end

endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One lookahead group. From its bits' generate/propagate terms and its carry-in
// it produces the carry into every bit, plus a group generate and propagate.
// Assumes: GRP_W <= 64; the carry-in comes from the second lookahead level.
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W = 4
) (
    input  logic [GRP_W-1:0] gen_bits,
    input  logic [GRP_W-1:0] prop_bits,
    input  logic             grp_cin,
    output logic [GRP_W-1:0] bit_carry,
    output logic             grp_gen,
    output logic             grp_prop
);

    // Widen the terms to the package vector size.
    logic [LA_MAX-1:0] g_wide;
    logic [LA_MAX-1:0] p_wide;

    // Zero-extended copies of the group's terms.
    always_comb begin
        g_wide             = '0;
        p_wide             = '0;
        g_wide[GRP_W-1:0]  = gen_bits;
        p_wide[GRP_W-1:0]  = prop_bits;
    end

    // Lookahead carry into each bit of the group.
    always_comb begin
        for (int unsigned k = 0; k < GRP_W; k++) begin
            bit_carry[k] = la_carry(g_wide, p_wide, grp_cin, k);
            AST_GRP_CARRY: assert (bit_carry[k] == rip_carry(g_wide, p_wide, grp_cin, k)) else $error("group carry %0d wrong", k); // R3
        end
    end

    // Group generate and propagate terms.
    always_comb begin
        grp_gen  = la_carry(g_wide, p_wide, 1'b0, GRP_W);
        grp_prop = &prop_bits;
        AST_GRP_GP_OUT: assert ((grp_gen | (grp_prop & grp_cin)) == rip_carry(g_wide, p_wide, grp_cin, GRP_W)) else $error("group G/P inconsistent"); // R4
    end

endmodule

// File: rtl/cla_level2.sv
// Module cla_level2
// Second lookahead level. It forms the carry into every group, and the final
// carry, from the group generate/propagate terms as flat sums of products.
// Assumes: N_GRP < 64.
module cla_level2
    import cla_pkg::*;
#(
    parameter int unsigned N_GRP = 4
) (
    input  logic [N_GRP-1:0] grp_gen,
    input  logic [N_GRP-1:0] grp_prop,
    input  logic             carry_in,
    output logic [N_GRP:0]   grp_carry
);

    logic [LA_MAX-1:0] gg_wide;
    logic [LA_MAX-1:0] gp_wide;

    // Zero-extended copies of the group terms.
    always_comb begin
        gg_wide            = '0;
        gp_wide            = '0;
        gg_wide[N_GRP-1:0] = grp_gen;
        gp_wide[N_GRP-1:0] = grp_prop;
    end

    // Carry into each group and out of the last one.
    always_comb begin
        for (int unsigned j = 0; j <= N_GRP; j++) begin
            grp_carry[j] = la_carry(gg_wide, gp_wide, carry_in, j);
            AST_L2_CARRY: assert (grp_carry[j] == rip_carry(gg_wide, gp_wide, carry_in, j)) else $error("level-2 carry %0d wrong", j); // R5
        end
    end

endmodule

// File: rtl/cla_adder.sv
// Module cla_adder
// Two-level carry-lookahead adder: per-bit generate/propagate, GROUP_W-bit
// lookahead groups, and a second lookahead level across the groups.
// Assumes: WIDTH is a multiple of GROUP_W; purely combinational, no reset.
module cla_adder #(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned GROUP_W = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int unsigned N_GRP = WIDTH / GROUP_W;

    logic [WIDTH-1:0] gen_bits;
    logic [WIDTH-1:0] prop_bits;
    logic [WIDTH-1:0] bit_carry;
    logic [N_GRP-1:0] grp_gen;
    logic [N_GRP-1:0] grp_prop;
    logic [N_GRP:0]   grp_carry;

    cla_bit_gp #(.WIDTH(WIDTH)) u_gp (
        .a_bits    (a_in),
        .b_bits    (b_in),
        .gen_bits  (gen_bits),
        .prop_bits (prop_bits)
    );

    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
        cla_group #(.GRP_W(GROUP_W)) u_grp (
            .gen_bits  (gen_bits[gi*GROUP_W +: GROUP_W]),
            .prop_bits (prop_bits[gi*GROUP_W +: GROUP_W]),
            .grp_cin   (grp_carry[gi]),
            .bit_carry (bit_carry[gi*GROUP_W +: GROUP_W]),
            .grp_gen   (grp_gen[gi]),
            .grp_prop  (grp_prop[gi])
        );
    end

    cla_level2 #(.N_GRP(N_GRP)) u_l2 (
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop),
        .carry_in  (carry_in),
        .grp_carry (grp_carry)
    );

    // Sum bits from operand bits and lookahead carries.
    always_comb begin
        sum_out   = a_in ^ b_in ^ bit_carry;
        carry_out = grp_carry[N_GRP];
    end

endmodule

// File: tb/cla_adder_tb.sv
// Bench cla_adder_tb_top
// Directed tasks, one per scenario, each checking its own results against
// plain integer addition.
module cla_adder_tb_top;

    localparam int unsigned W = 16;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic         carry_in;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int n_vec;
    int n_fail;
    bit done;

    cla_adder #(.WIDTH(W), .GROUP_W(4)) dut_i (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // 100 MHz clock.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Apply one vector, wait for settling away from the edge, compare.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input string req);
        logic [W:0] exp;
        @(negedge clk);
        a_in     = a;
        b_in     = b;
        carry_in = ci;
        #2;
        exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        n_vec++;
        if (sum_out !== exp[W-1:0] || carry_out !== exp[W]) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h ci=%b got sum=%h cout=%b exp sum=%h cout=%b",
                     req, a, b, ci, sum_out, carry_out, exp[W-1:0], exp[W]);
        end
    endtask

    // Reset state: zero operands give zero sum and no carry (R6, R7).
    task automatic t_reset;
        apply('0, '0, 1'b0, "R6/R7 reset zero");
    endtask

    // Generate-only bits: equal operands (R1).
    task automatic t_generate;
        apply(16'h0001, 16'h0001, 1'b0, "R1 single generate");
        apply(16'h8000, 16'h8000, 1'b0, "R1 top generate R7");
        apply(16'h5555, 16'h5555, 1'b1, "R1 alternating generate");
    endtask

    // Propagate chains inside one group and across group edges (R2, R3).
    task automatic t_propagate;
        apply(16'h0007, 16'h0001, 1'b0, "R2 in-group chain R3");
        apply(16'h000E, 16'h0000, 1'b1, "R3 carry-in blocked at bit0");
        apply(16'h000F, 16'h0000, 1'b1, "R2 group chain via carry_in");
        apply(16'h0FF0, 16'h0010, 1'b0, "R3 chain crossing groups");
    endtask

    // Carry from the top of each group into the next propagating group (R4, R5, R9).
    task automatic t_group_edges;
        for (int k = 0; k < 3; k++) begin
            apply(16'h0008 << (4*k), (16'h0008 << (4*k)) | (16'h00F0 << (4*k)), 1'b0, "R9 group edge skip");
            apply(16'h000F << (4*k), 16'h0001 << (4*k), 1'b0, "R4 group generate out R5");
        end
        apply(16'hF000, 16'h1000, 1'b0, "R5 final carry from last group R7");
    endtask

    // Longest propagate chain with carry on and off (R8).
    task automatic t_full_chain;
        apply(16'hFFFF, 16'h0000, 1'b1, "R8 all ones plus carry_in");
        apply(16'hFFFF, 16'h0000, 1'b0, "R8 all ones no carry_in");
        apply(16'hAAAA, 16'h5555, 1'b1, "R8 all propagate mixed");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R7 maximum inputs");
    endtask

    // Random operands against integer addition (R6, R7).
    task automatic t_random;
        for (int i = 0; i < 3000; i++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "R6/R7 random");
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(100000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    // Test sequence.
    initial begin
        n_vec    = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        a_in     = '0;
        b_in     = '0;
        carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_generate();
        t_propagate();
        t_group_edges();
        t_full_chain();
        t_random();
        finish_run();
    end

endmodule